// File: doc/BRIEF.md
# Fault Rerouting Tag Converter

This block sits beside a switch in a multistage network that offers two disjoint paths between every source and destination. Each packet has two routing tags: a downward tag and an upward tag. When the packet, sitting at stage i-1, finds that the switch or link it needs at stage i is faulty or busy, the block turns the tag in use into a rerouting tag. The packet then leaves the failing path and joins the other disjoint path. The block also reports whether the packet first has to travel back over the reverse straight link to the switch it came from.

A tag has N+1 positions, numbered 0 to N. Each position holds a 2-bit digit, and position k sits at bits [2k+1:2k]. Positions 0 and 1 together form the code for the stage-0 link, with each of those digits 0 or 1. Each position k of 2 or more holds the link taken into stage k: 0 for straight, 1 for downward non-straight, 2 for upward non-straight. Digit value 3 is never legal.

The caller presents both tags, a flag that names the tag in use, and the stage index of the fault, and raises a request for one cycle. One cycle later the result appears with a valid pulse. The result stays on the outputs until the next request.

Top module: `reroute_tag_conv`

## Requirements
- R1: A request raised at a clock edge gives a valid pulse exactly one cycle later, lasting one cycle. Without a request, valid stays low and the result outputs hold their values.
- R2: At stage 1, the stage-0 link code is rewritten. Pair 10 becomes 00, 00 becomes 10, 11 becomes 01, and 01 becomes 11, so digit 0 is inverted and digit 1 is kept. Positions 2 to N are taken from the other tag. The back flag is 0.
- R3: At a stage i from 2 to N, if digit i of the current tag is 1 it becomes 2. Positions above i come from the other tag, positions below i are kept, and the back flag is 0.
- R4: At a stage i from 2 to N, if digit i of the current tag is 2 it becomes 1. Positions above i come from the other tag, positions below i are kept, and the back flag is 0.
- R5: At a stage i from 2 to N, if digit i of the current tag is 0 (straight), positions i to N are all taken from the other tag. The back flag is 1, meaning one reverse hop.
- R6: After every valid reroute, the direction output names the other tag. Direction 0 means downward and 1 means upward.
- R7: A stage index of 0 or above N sets the error flag. The current tag is then passed through unchanged, the direction is kept, and the back flag is 0.
- R8: Digit value 3 at position i (for i of 2 or more) sets the error flag with the same pass-through. So does a digit above 1 in position 0 or 1 when i is 1.
- R9: After reset, valid, tag, direction, back and error outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request: sample inputs this edge |
| dir_up_i | input | 1 | Tag in use: 0 downward, 1 upward |
| down_tag_i | input | 2*(N_STAGES+1) | Downward tag |
| up_tag_i | input | 2*(N_STAGES+1) | Upward tag |
| stage_i | input | $clog2(N_STAGES+2) | Stage index of the faulty element |
| vld_o | output | 1 | Result valid pulse |
| tag_o | output | 2*(N_STAGES+1) | Tag to follow next |
| dir_up_o | output | 1 | Direction of the tag to follow |
| back_o | output | 1 | Reverse straight hop needed |
| err_o | output | 1 | Stage or digit illegal; tag passed through |

## Verification
The converter is tried with the two tag pairs 1000/0022 and 1101/0122. Each pair is used from both directions, and the fault stage is set to 1, 2 and 3. This reaches all four stage-0 pair codes and each digit value 0, 1 and 2 at the examined position. Runs with the fault in the last stage and in a middle stage show whether the positions below i are kept and the positions above i are spliced in from the other tag. Further runs use stage indices 0 and 4 and inject digit value 3 and an illegal pair digit, to separate the pass-through path from the reroute. Back-to-back requests and idle cycles confirm the one-cycle pulse and the held result.

// File: rtl/reroute_tag_conv.sv
module reroute_tag_conv #(
  parameter int N_STAGES = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_i,
  input  logic                           dir_up_i,
  input  logic [2*(N_STAGES+1)-1:0]      down_tag_i,
  input  logic [2*(N_STAGES+1)-1:0]      up_tag_i,
  input  logic [$clog2(N_STAGES+2)-1:0]  stage_i,
  output logic                           vld_o,
  output logic [2*(N_STAGES+1)-1:0]      tag_o,
  output logic                           dir_up_o,
  output logic                           back_o,
  output logic                           err_o
);
  localparam int TW = 2*(N_STAGES+1);

  logic [TW-1:0] cur, oth, nxt;
  logic          err_c, back_c;

  assign cur = dir_up_i ? up_tag_i   : down_tag_i;
  assign oth = dir_up_i ? down_tag_i : up_tag_i;

  always_comb begin
    int s;
    logic [1:0] dig, nd;
    s      = int'(stage_i);
    nxt    = cur;
    err_c  = 1'b0;
    back_c = 1'b0;
    dig    = 2'd0;
    nd     = 2'd0;
    if (s == 0 || s > N_STAGES) begin
      err_c = 1'b1;
    end else if (s == 1) begin
      if (cur[1] || cur[3]) err_c = 1'b1;
      else begin
        nxt[1:0] = {1'b0, ~cur[0]};
        for (int k = 2; k <= N_STAGES; k++) nxt[2*k +: 2] = oth[2*k +: 2];
      end
    end else begin
      dig = cur[2*s +: 2];
      case (dig)
        2'd1:    nd = 2'd2;
        2'd2:    nd = 2'd1;
        2'd0:    begin nd = oth[2*s +: 2]; back_c = 1'b1; end
        default: err_c = 1'b1;
      endcase
      if (!err_c)
        for (int k = 2; k <= N_STAGES; k++) begin
          if (k == s)     nxt[2*k +: 2] = nd;
          else if (k > s) nxt[2*k +: 2] = oth[2*k +: 2];
        end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o    <= 1'b0;
      tag_o    <= '0;
      dir_up_o <= 1'b0;
      back_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        tag_o    <= err_c ? cur : nxt;
        dir_up_o <= err_c ? dir_up_i : ~dir_up_i;
        back_o   <= err_c ? 1'b0 : back_c;
        err_o    <= err_c;
      end
    end
  end

  a_r1_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> vld_o);
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> (!vld_o && $stable(tag_o) && $stable(dir_up_o)));
  a_r6_dir_flips: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (err_o || dir_up_o != $past(dir_up_i)));
  a_r7_err_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> (!err_o || (dir_up_o == $past(dir_up_i) && !back_o)));
  a_r7_bad_stage_err: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && (stage_i == '0 || int'(stage_i) > N_STAGES)) |=> err_o);
endmodule

// File: tb/reroute_tag_conv_bench.sv
module reroute_tag_conv_bench;
  localparam int N  = 3;
  localparam int TW = 2*(N+1);
  localparam int SW = $clog2(N+2);

  logic clk = 0, rst_n = 0, req = 0, dir_in = 0;
  logic [TW-1:0] dn = '0, up = '0;
  logic [SW-1:0] st = '0;
  logic vld, dir_out, back, err;
  logic [TW-1:0] tag;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  reroute_tag_conv #(.N_STAGES(N)) u_reroute_tag_conv (
    .clk(clk), .rst_n(rst_n), .req_i(req), .dir_up_i(dir_in),
    .down_tag_i(dn), .up_tag_i(up), .stage_i(st),
    .vld_o(vld), .tag_o(tag), .dir_up_o(dir_out), .back_o(back), .err_o(err));

  // {dir, down, up, stage, exp_tag, exp_dir, exp_back, exp_err}
  localparam int NV = 14;
  localparam logic [30:0] VEC [NV] = '{
    {1'b1, 8'b00_00_00_01, 8'b10_10_00_00, 3'd2, 8'b00_01_00_00, 1'b0, 1'b0, 1'b0}, // R4
    {1'b0, 8'b00_00_00_01, 8'b10_10_00_00, 3'd1, 8'b10_10_00_00, 1'b1, 1'b0, 1'b0}, // R2 10->00
    {1'b1, 8'b00_00_00_01, 8'b10_10_00_00, 3'd1, 8'b00_00_00_01, 1'b0, 1'b0, 1'b0}, // R2 00->10
    {1'b0, 8'b00_00_00_01, 8'b10_10_00_00, 3'd2, 8'b10_10_00_01, 1'b1, 1'b1, 1'b0}, // R5
    {1'b0, 8'b01_00_01_01, 8'b10_10_01_00, 3'd3, 8'b10_00_01_01, 1'b1, 1'b0, 1'b0}, // R3
    {1'b1, 8'b01_00_01_01, 8'b10_10_01_00, 3'd1, 8'b01_00_01_01, 1'b0, 1'b0, 1'b0}, // R2 01->11
    {1'b0, 8'b01_00_01_01, 8'b10_10_01_00, 3'd1, 8'b10_10_01_00, 1'b1, 1'b0, 1'b0}, // R2 11->01
    {1'b1, 8'b01_00_01_01, 8'b10_10_01_00, 3'd3, 8'b01_10_01_00, 1'b0, 1'b0, 1'b0}, // R4
    {1'b1, 8'b01_00_01_01, 8'b10_10_01_00, 3'd2, 8'b01_01_01_00, 1'b0, 1'b0, 1'b0}, // R4 splice
    {1'b0, 8'b01_00_01_01, 8'b10_10_01_00, 3'd0, 8'b01_00_01_01, 1'b0, 1'b0, 1'b1}, // R7
    {1'b1, 8'b01_00_01_01, 8'b10_10_01_00, 3'd4, 8'b10_10_01_00, 1'b1, 1'b0, 1'b1}, // R7
    {1'b0, 8'b00_11_00_01, 8'b10_10_00_00, 3'd2, 8'b00_11_00_01, 1'b0, 1'b0, 1'b1}, // R8
    {1'b0, 8'b00_00_00_10, 8'b10_10_00_00, 3'd1, 8'b00_00_00_10, 1'b0, 1'b0, 1'b1}, // R8
    {1'b0, 8'b00_01_00_01, 8'b10_10_00_00, 3'd3, 8'b10_01_00_01, 1'b1, 1'b1, 1'b0}  // R5 R3 R6
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic drive(input logic [30:0] v);
    @(negedge clk);
    dir_in = v[30]; dn = v[29:22]; up = v[21:14]; st = v[13:11]; req = 1;
    @(negedge clk);
    req = 0;
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset", {27'd0, vld, tag[3:0], err}, 32'd0);
    chk("R9 reset outs", {24'd0, tag, dir_out, back, 6'd0}, 32'd0);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      chk("R1 valid", {31'd0, vld}, 32'd1);
      chk("R2-R8 tag", {24'd0, tag}, {24'd0, VEC[i][10:3]});
      chk("R6 dir", {31'd0, dir_out}, {31'd0, VEC[i][2]});
      chk("R5 back", {31'd0, back}, {31'd0, VEC[i][1]});
      chk("R7 err", {31'd0, err}, {31'd0, VEC[i][0]});
    end
    // R1: idle cycle, valid drops, result holds
    @(negedge clk);
    chk("R1 idle vld", {31'd0, vld}, 32'd0);
    chk("R1 hold tag", {24'd0, tag}, {24'd0, VEC[NV-1][10:3]});
    dn = 8'hFF; st = 3'd0; dir_in = 1;
    @(negedge clk);
    chk("R1 no req ignored", {23'd0, tag, dir_out}, {23'd0, VEC[NV-1][10:3], 1'b1});
    // R1: back-to-back requests
    @(negedge clk);
    dir_in = VEC[1][30]; dn = VEC[1][29:22]; up = VEC[1][21:14]; st = VEC[1][13:11]; req = 1;
    @(negedge clk);
    chk("R1 b2b first", {23'd0, vld, tag}, {23'd1, VEC[1][10:3]});
    dir_in = VEC[3][30]; dn = VEC[3][29:22]; up = VEC[3][21:14]; st = VEC[3][13:11];
    @(negedge clk);
    req = 0;
    chk("R1 b2b second", {22'd0, vld, tag, back}, {22'd0, 1'b1, VEC[3][10:3], 1'b1});
    // R9: reset again clears
    rst_n = 0;
    @(negedge clk);
    chk("R9 re-reset", {21'd0, vld, tag, dir_out, back, err}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule